// File: doc/BRIEF.md
# Hex Mesh Broadcast Route Decoder

This block decides where one node of a hexagonal processor mesh forwards a broadcast packet. It takes the direction the packet came from, the packet's detour flag and the node's own border position. It returns a six-bit mask of neighbour links that get a copy, and the detour flag that each copy carries. The rule set is built so that a packet injected from the layer below reaches every node of the layer exactly once, with no copy sent twice to the same node.

Direction codes are: 0 = arrived from the layer below; 1 = travelling from lower-right toward upper-left; 2 = travelling upward; 3 = travelling from lower-left toward upper-right; 4 = travelling from upper-left toward lower-right; 5 = travelling downward; 6 = travelling from upper-right toward lower-left. Code 7 is not a valid arrival code. A copy sent on link i carries direction code i to the receiving node.

The decision is registered behind a one-entry valid/ready stage. It produces one result per accepted request, so the block can sit directly in front of an outgoing packet queue.

Top module: `hexcast_route`

## Requirements
- R1: An arrival code of 0 selects all six links (mask 6'h3F) with every detour bit clear, whatever the detour input and border flags are.
- R2: With detour clear, code 1 selects link 1 and code 4 selects link 4, each with detour clear. If either border flag is high, code 1 also selects link 6 and code 4 also selects link 3, both with detour clear.
- R3: With detour clear, code 2 selects links 1, 2 and 3, with detour set on 1 and 3. Code 5 selects links 4, 5 and 6, with detour set on 4 and 6.
- R4: With detour clear, code 3 selects links 3 and 4, with detour set on 4. Code 6 selects links 6 and 1, with detour set on 1.
- R5: With detour set and codes 1 to 6, only the arrival link is selected, and its detour stays set. R6 and R7 are the exceptions.
- R6: With detour set, code 4 and the upper-border flag high, only link 3 is selected, with detour clear.
- R7: With detour set, code 1 and the lower-border flag high, links 1, 3, 4 and 6 are selected. Detour stays set on link 1 and is clear on links 3, 4 and 6.
- R8: Arrival code 7 yields a valid result with an empty mask and all detour bits clear.
- R9: Mask bit i-1 and detour bit i-1 belong to link i. A detour bit is never set for a link outside the mask.
- R10: An accepted request (in_valid and in_ready both high at a clock edge) produces its result with out_valid high after that edge. in_ready equals (not out_valid) or out_ready. While out_valid is high and out_ready is low, the result and out_valid stay unchanged.
- R11: While in reset, and after it, until a request is accepted, out_valid is low. in_ready goes high once the synchronised reset release has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted at this edge when in_valid is high |
| in_dir | input | 3 | Arrival direction code, 0 to 6 |
| in_detour | input | 1 | Detour flag of the arriving packet |
| edge_upper | input | 1 | Node sits on the upper border of the layer |
| edge_lower | input | 1 | Node sits on the lower border of the layer |
| out_valid | output | 1 | Routing result present |
| out_ready | input | 1 | Consumer takes the result at this edge |
| out_mask | output | 6 | Links that get a copy; bit i-1 is link i |
| out_detour | output | 6 | Detour flag for the copy on each selected link |

## Verification
Every result appears one clock edge after acceptance. The bench drives each request half a period ahead of the accepting edge and reads out_mask, out_detour and out_valid on the following falling edge, exactly one register stage later. All 64 combinations of code, detour and border flags are swept with consumer ready held high. Then a stall holds out_ready low for several cycles while a different request waits. in_ready is checked combinationally right after out_ready changes, and the waiting request is checked on the falling edge after the edge that accepts it.

// File: rtl/hexcast_pkg.sv
package hexcast_pkg;
  localparam int unsigned LINKS  = 6;
  localparam int unsigned CODE_W = 3;

  typedef logic [LINKS-1:0]  link_vec_t;
  typedef logic [CODE_W-1:0] code_t;

  typedef struct packed {
    link_vec_t mask;
    link_vec_t detour;
  } route_t;

  localparam code_t CODE_BELOW = code_t'(0);
  localparam code_t CODE_BAD   = code_t'(7);

  // one-hot vector for link number 1..LINKS
  function automatic link_vec_t link_bit(input int unsigned n);
    link_vec_t v;
    v = '0;
    if (n >= 1 && n <= LINKS) v[n-1] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/hexcast_rstsync.sv
module hexcast_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/hexcast_rule.sv
module hexcast_rule
  import hexcast_pkg::*;
(
  input  code_t  dir_code,
  input  logic   detour_in,
  input  logic   upper_edge,
  input  logic   lower_edge,
  output route_t route
);
  link_vec_t sel;
  link_vec_t keep;      // detour flag per selected link
  logic      on_edge;

  assign on_edge = upper_edge | lower_edge;

  always_comb begin
    sel  = '0;
    keep = '0;
    if (dir_code == CODE_BELOW) begin
      sel = '1;
    end else if (dir_code == CODE_BAD) begin
      sel = '0;
    end else if (!detour_in) begin
      unique case (dir_code)
        code_t'(1): begin
          sel = link_bit(1) | (on_edge ? link_bit(6) : '0);
        end
        code_t'(2): begin
          sel  = link_bit(1) | link_bit(2) | link_bit(3);
          keep = link_bit(1) | link_bit(3);
        end
        code_t'(3): begin
          sel  = link_bit(3) | link_bit(4);
          keep = link_bit(4);
        end
        code_t'(4): begin
          sel = link_bit(4) | (on_edge ? link_bit(3) : '0);
        end
        code_t'(5): begin
          sel  = link_bit(4) | link_bit(5) | link_bit(6);
          keep = link_bit(4) | link_bit(6);
        end
        code_t'(6): begin
          sel  = link_bit(6) | link_bit(1);
          keep = link_bit(1);
        end
        default: begin
          sel  = '0;
          keep = '0;
        end
      endcase
    end else if (upper_edge && dir_code == code_t'(4)) begin
      sel = link_bit(3);
    end else if (lower_edge && dir_code == code_t'(1)) begin
      sel  = link_bit(1) | link_bit(3) | link_bit(4) | link_bit(6);
      keep = link_bit(1);
    end else begin
      sel  = link_bit(int'(dir_code));
      keep = link_bit(int'(dir_code));
    end
  end

  assign route.mask   = sel;
  assign route.detour = keep;
endmodule

// File: rtl/hexcast_slot.sv
module hexcast_slot #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         live,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic         full_q, full_d;
  logic [W-1:0] data_q;
  logic         load_en;

  assign up_ready = live & (~full_q | dn_ready);
  assign load_en  = up_valid & up_ready;

  always_comb begin
    full_d = full_q;
    if (load_en)       full_d = 1'b1;
    else if (dn_ready) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (load_en) data_q <= up_data;
  end

  assign dn_valid = full_q;
  assign dn_data  = data_q;
endmodule

// File: rtl/hexcast_route.sv
module hexcast_route
  import hexcast_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [2:0] in_dir,
  input  logic       in_detour,
  input  logic       edge_upper,
  input  logic       edge_lower,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [5:0] out_mask,
  output logic [5:0] out_detour
);
  localparam int unsigned PAY_W = $bits(route_t);

  logic   rst_n_sync;
  route_t decided;
  route_t held;

  hexcast_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  hexcast_rule u_rule (
    .dir_code   (in_dir),
    .detour_in  (in_detour),
    .upper_edge (edge_upper),
    .lower_edge (edge_lower),
    .route      (decided)
  );

  hexcast_slot #(.W(PAY_W)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .live     (rst_n_sync),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (decided),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (held)
  );

  assign out_mask   = held.mask;
  assign out_detour = held.detour;
endmodule

// File: rtl/hexcast_route_chk.sv
module hexcast_route_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [2:0] in_dir,
  input logic       out_valid,
  input logic       out_ready,
  input logic [5:0] out_mask,
  input logic [5:0] out_detour
);
  p_result_due_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_mask) && $stable(out_detour)));

  p_stall_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_detour_in_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_detour & ~out_mask) == 6'h00));

  p_below_all_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_dir == 3'd0) |=> (out_mask == 6'h3F && out_detour == 6'h00));

  p_bad_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_dir == 3'd7) |=> (out_mask == 6'h00));

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !(in_valid && in_ready)) |=> !out_valid);
endmodule

bind hexcast_route hexcast_route_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_dir     (in_dir),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_mask   (out_mask),
  .out_detour (out_detour)
);

// File: tb/hexcast_route_test.sv
`timescale 1ns/1ps
module hexcast_route_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] in_dir = 3'd0;
  logic       in_detour = 1'b0;
  logic       edge_upper = 1'b0;
  logic       edge_lower = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [5:0] out_mask;
  logic [5:0] out_detour;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hexcast_route uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dir(in_dir), .in_detour(in_detour), .edge_upper(edge_upper),
    .edge_lower(edge_lower), .out_valid(out_valid), .out_ready(out_ready),
    .out_mask(out_mask), .out_detour(out_detour)
  );

  function automatic logic [5:0] lk(input int n);
    return 6'(1) << (n - 1);
  endfunction

  // independent reference: builds the copy set from the rule list
  task automatic model(input int d, input bit det, input bit up, input bit lo,
                       output logic [5:0] m, output logic [5:0] t, output string tag);
    m = 0; t = 0;
    if (d == 0) begin m = 6'h3F; tag = "R1"; end
    else if (d == 7) begin tag = "R8"; end
    else if (!det) begin
      if (d == 1 || d == 4) begin
        m = lk(d);
        if (up || lo) m = m | lk(d == 1 ? 6 : 3);
        tag = "R2";
      end else if (d == 2 || d == 5) begin
        m = lk(d - 1) | lk(d) | lk(d + 1);
        t = lk(d - 1) | lk(d + 1);
        tag = "R3";
      end else begin
        m = lk(d) | lk(d == 3 ? 4 : 1);
        t = lk(d == 3 ? 4 : 1);
        tag = "R4";
      end
    end else if (up && d == 4) begin m = lk(3); tag = "R6"; end
    else if (lo && d == 1) begin
      m = lk(1) | lk(3) | lk(4) | lk(6);
      t = lk(1);
      tag = "R7";
    end else begin m = lk(d); t = lk(d); tag = "R5"; end
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [5:0] em, et;
    string tag;
    repeat (3) @(negedge clk);
    check("R11", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11", "out_valid after reset", out_valid, 0);
    check("R11", "in_ready after reset", in_ready, 1);

    // full sweep, consumer always ready
    for (int v = 0; v < 64; v++) begin
      in_dir = v[2:0]; in_detour = v[3]; edge_upper = v[4]; edge_lower = v[5];
      in_valid = 1'b1;
      model(v & 7, v[3], v[4], v[5], em, et, tag);
      @(negedge clk);
      in_valid = 1'b0;
      check("R10", "out_valid one edge after accept", out_valid, 1);
      check(tag, $sformatf("mask code=%0d det=%0d up=%0d lo=%0d", v & 7, v[3], v[4], v[5]), out_mask, em);
      check(tag, "detour bits", out_detour, et);
      check("R9", "detour outside mask", out_detour & ~out_mask, 0);
    end
    @(negedge clk);
    check("R10", "out_valid drops when idle", out_valid, 0);

    // stall: code 2 accepted, consumer stops, code 5 waits
    out_ready = 1'b0;
    in_dir = 3'd2; in_detour = 0; edge_upper = 0; edge_lower = 0; in_valid = 1;
    @(negedge clk);
    in_dir = 3'd5;
    check("R3", "stalled mask", out_mask, 6'h07);
    check("R10", "in_ready low on stall", in_ready, 0);
    repeat (3) @(negedge clk);
    check("R10", "held valid", out_valid, 1);
    check("R10", "held mask", out_mask, 6'h07);
    check("R10", "held detour", out_detour, 6'h05);
    out_ready = 1'b1;
    #1;
    check("R10", "in_ready follows out_ready", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R3", "waiting request mask", out_mask, 6'h38);
    check("R3", "waiting request detour", out_detour, 6'h28);
    @(negedge clk);
    check("R10", "empty after drain", out_valid, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule